// File: doc/BRIEF.md
# Arbitrary Length Burst Splitter

This block sits in front of the burst engine of a memory-to-memory copy unit with a 64-bit data path. A start request carries a byte count of any length. The block breaks that count into a short series of burst descriptors. Each descriptor names a beat count and a beat size. The engine consumes the descriptors one at a time over a valid/ready handshake.

Descriptors come out in three groups, always in the same order:

1. As many full-length, full-width bursts as the count allows (16 beats of 8 bytes, so 128 bytes each).
2. At most one shorter full-width burst covering the remaining whole doublewords.
3. At most one burst of single-byte beats covering the last odd bytes.

A group that would be empty produces no descriptor. A one-cycle done pulse marks the end of each request.

Top module: `burst_splitter`

## Requirements
- R1: After reset the outputs `busy`, `desc_valid` and `done` are all low.
- R2: A request of N bytes first yields floor(N/128) descriptors, each with `desc_beats`=16 and `desc_size`=3. Size code 3 means 8-byte beats.
- R3: If (N mod 128)/8 is nonzero, exactly one descriptor follows the full bursts, with `desc_beats`=(N mod 128)/8 and `desc_size`=3. Otherwise this descriptor is omitted.
- R4: If N mod 8 is nonzero, exactly one last descriptor follows, with `desc_beats`=N mod 8 and `desc_size`=0. Size code 0 means 1-byte beats. Otherwise this descriptor is omitted.
- R5: The descriptor order is always: full bursts, then the doubleword burst, then the byte burst. No descriptor ever has zero beats.
- R6: While `desc_valid` is high and `desc_ready` is low, `desc_valid`, `desc_beats` and `desc_size` hold their values into the next cycle.
- R7: `done` is high for exactly one cycle. That cycle immediately follows the clock edge that accepts the last descriptor.
- R8: A byte count of zero yields no descriptor. In that case `done` is high in the cycle right after the start edge.
- R9: `start` is ignored while `busy` is high. It neither alters the descriptors of the running request nor begins a new one once the running request ends.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle, and low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| byte_count | input | 20 | Total bytes of the request |
| busy | output | 1 | A request is being split |
| desc_valid | output | 1 | A descriptor is presented |
| desc_ready | input | 1 | The consumer takes the descriptor |
| desc_beats | output | 5 | Beats in the burst (1 to 16) |
| desc_size | output | 3 | Beat size code: 3 = 8 bytes, 0 = 1 byte |
| done | output | 1 | One-cycle pulse after the last descriptor |

## Verification
The hardest situations to reach are phase changes that happen while the consumer stalls. The first is a full-to-doubleword switch with a descriptor held through several low-ready cycles. The second is a start strobe that lands during the done cycle, while the block still counts as busy.

The stimulus withholds `desc_ready` at random on about a quarter of the cycles. It also mixes directed counts with random counts across every remainder class. Some of those counts skip the middle group, some skip the last group, and some skip both. It injects a second start during runs of one, two and many descriptors. It then confirms that the descriptor stream matches the first count and that `busy` falls after `done`.

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int CNT_W      = 20,
  parameter int MAX_BEATS  = 16,
  parameter int BEAT_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [4:0]       desc_beats,
  output logic [2:0]       desc_size,
  output logic             done
);
  localparam int BEAT_SH  = $clog2(BEAT_BYTES);
  localparam int BURST_SH = $clog2(MAX_BEATS * BEAT_BYTES);
  localparam int FULL_W   = CNT_W - BURST_SH;
  localparam int WORD_W   = BURST_SH - BEAT_SH;
  localparam logic [2:0] WIDE_CODE = 3'(BEAT_SH);

  typedef enum logic [2:0] {S_IDLE, S_FULL, S_WORD, S_TAIL, S_FIN} phase_t;

  phase_t              phase;
  logic [FULL_W-1:0]   full_q;
  logic [WORD_W-1:0]   word_q;
  logic [BEAT_SH-1:0]  tail_q;
  logic                fire;

  assign busy       = (phase != S_IDLE);
  assign done       = (phase == S_FIN);
  assign desc_valid = (phase == S_FULL) || (phase == S_WORD) || (phase == S_TAIL);
  assign fire       = desc_valid && desc_ready;

  always_comb begin
    desc_beats = '0;
    desc_size  = '0;
    case (phase)
      S_FULL: begin desc_beats = 5'(MAX_BEATS); desc_size = WIDE_CODE; end
      S_WORD: begin desc_beats = 5'(word_q);    desc_size = WIDE_CODE; end
      S_TAIL: begin desc_beats = 5'(tail_q);    desc_size = 3'd0;      end
      default: ;
    endcase
  end

  function automatic phase_t after_full(input logic [WORD_W-1:0] w, input logic [BEAT_SH-1:0] t);
    if (w != '0)      return S_WORD;
    else if (t != '0) return S_TAIL;
    else              return S_FIN;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= S_IDLE;
      full_q <= '0;
      word_q <= '0;
      tail_q <= '0;
    end else begin
      case (phase)
        S_IDLE: if (start) begin
          full_q <= byte_count[CNT_W-1:BURST_SH];
          word_q <= byte_count[BURST_SH-1:BEAT_SH];
          tail_q <= byte_count[BEAT_SH-1:0];
          if (byte_count[CNT_W-1:BURST_SH] != '0) phase <= S_FULL;
          else phase <= after_full(byte_count[BURST_SH-1:BEAT_SH], byte_count[BEAT_SH-1:0]);
        end
        S_FULL: if (fire) begin
          full_q <= full_q - 1'b1;
          if (full_q == FULL_W'(1)) phase <= after_full(word_q, tail_q);
        end
        S_WORD: if (fire) phase <= (tail_q != '0) ? S_TAIL : S_FIN;
        S_TAIL: if (fire) phase <= S_FIN;
        default: phase <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!desc_valid && !done));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_beats) && $stable(desc_size)));

  p_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_beats != 5'd0 && desc_beats <= 5'(MAX_BEATS)));

  p_byte_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready && desc_size == 3'd0) |=> done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !desc_valid));
endmodule

// File: tb/tb_burst_splitter.sv
module tb_burst_splitter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [19:0] byte_count = 0;
  logic        desc_ready = 0;
  logic        busy, desc_valid, done;
  logic [4:0]  desc_beats;
  logic [2:0]  desc_size;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  burst_splitter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .busy(busy), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_beats(desc_beats), .desc_size(desc_size), .done(done)
  );

  function automatic int n_desc(input int c);
    return (c >> 7) + ((((c >> 3) & 15) != 0) ? 1 : 0) + (((c & 7) != 0) ? 1 : 0);
  endfunction

  function automatic void exp_desc(input int c, input int k, output int eb, output int es, output string rq);
    int nf, nw;
    nf = c >> 7;
    nw = (c >> 3) & 15;
    if (k < nf) begin
      eb = 16; es = 3; rq = "R2";
    end else if (k == nf && nw != 0) begin
      eb = nw; es = 3; rq = "R3";
    end else begin
      eb = c & 7; es = 0; rq = "R4";
    end
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run(input int c, input int poke_at, input int stall_pct);
    int n, got, cyc, eb, es, pb, ps;
    bit fin, last_acc, prev_hold, busy_ok, hold_ok, desc_ok, r;
    string rq;
    n = n_desc(c);
    got = 0; cyc = 0; fin = 0; last_acc = 0; prev_hold = 0;
    busy_ok = 1; hold_ok = 1; desc_ok = 1; pb = 0; ps = 0;
    @(negedge clk);
    start = 1; byte_count = 20'(c); desc_ready = 0;
    @(negedge clk);
    start = 0;
    while (!fin && cyc < 40000) begin
      if (busy !== 1'b1) busy_ok = 0;
      if (prev_hold && (desc_valid !== 1'b1 || int'(desc_beats) != pb || int'(desc_size) != ps)) hold_ok = 0;
      if (done === 1'b1) begin
        // R7 / R8: done lands right after the last accept (or right after start for zero)
        check((n == 0 && cyc == 0) || (n > 0 && last_acc), (n == 0) ? "R8" : "R7", cyc, got);
        check(desc_valid === 1'b0, "R7", desc_valid, 0);
        fin = 1;
      end else begin
        start = (cyc == poke_at);
        byte_count = (cyc == poke_at) ? 20'(c ^ 20'h5a5a3) : 20'(c);
        r = ($urandom % 100) >= stall_pct;
        desc_ready = r;
        last_acc = 0;
        if (desc_valid === 1'b1 && r) begin
          if (got < n) begin
            exp_desc(c, got, eb, es, rq);
            if (int'(desc_beats) != eb || int'(desc_size) != es) begin
              if (desc_ok) check(0, rq, int'(desc_beats) * 10 + int'(desc_size), eb * 10 + es);
              desc_ok = 0;
            end
          end
          got++;
          last_acc = (got == n);
        end
        prev_hold = (desc_valid === 1'b1) && !r;
        pb = int'(desc_beats);
        ps = int'(desc_size);
        @(negedge clk);
        cyc++;
      end
    end
    start = 0; desc_ready = 0;
    check(fin, "R7 watchdog", cyc, n);
    check(desc_ok, "R2 R3 R4 R5 descriptor values", 0, 1);
    check(got == n, "R5 descriptor count", got, n);
    check(hold_ok, "R6 hold under stall", 0, 1);
    check(busy_ok, "R10 busy during run", 0, 1);
    @(negedge clk);
    // R9: a start poked while busy must not have launched a new request
    check(busy === 1'b0 && done === 1'b0, (poke_at >= 0) ? "R9" : "R10", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && desc_valid === 1'b0 && done === 1'b0, "R1", {busy, desc_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0 && desc_valid === 1'b0, "R1", {busy, desc_valid}, 0);
    void'($urandom(32'd1234));
    run(699, -1, 25);
    run(0, -1, 0);
    run(0, 0, 0);
    run(128, -1, 50);
    run(1280, 3, 30);
    run(8, 0, 0);
    run(7, 1, 60);
    run(127, 2, 40);
    run(1, -1, 0);
    run(136, 1, 20);
    run(131, 2, 20);
    run(120, 1, 70);
    run(1048575, 50, 10);
    for (int i = 0; i < 40; i++) begin
      int c;
      case (i % 3)
        0: c = $urandom % 256;
        1: c = $urandom % 4096;
        default: c = $urandom % 20000;
      endcase
      run(c, $urandom % 8, $urandom % 60);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule